// File: doc/BRIEF.md
# Programmable Pixel Clock Generator

This block derives a pixel clock from a clock that runs at twice the master rate. Each cycle of that fast clock is one half-master step. The block builds a square wave whose period is set in whole master clocks. It can shift the wave later in half-master steps and can invert it. Alongside the pixel clock it produces two more signals:
- a single-cycle enable, which tells the data and sync output registers of the pixel port when to update, so that they change on the chosen pixel-clock edge;
- an ADC clock, whose period in master clocks does not depend on the readout power mode.

A phase state machine alternates between a high phase and a low phase of equal length. The programmed settings are held in shadow registers. These are reloaded only on the transition from the low phase (or from the start-up load state) into the high phase. That transition is the pixel-clock period boundary. The delay is a tap on a shift line of the undelayed wave. The states are PH_LOAD (the single cycle after reset), PH_HIGH and PH_LOW. The transitions are LOAD→HIGH (always), HIGH→LOW (high phase count done) and LOW→HIGH (low phase count done, settings reloaded).

Top module: `pixclk_gen`

## Requirements
- R1: While reset is held, pixclk_o, launch_o and adcclk_o are all 0. The shadow settings reset to period 1, delay 1, no inversion and full power.
- R2: In full-power mode with a constant period setting P (1..15), pixclk_o has a period of 2·P fast-clock cycles, with P cycles high and P cycles low.
- R3: A period setting of 0 produces exactly the waveform of a period setting of 1.
- R4: With lowpwr_i = 1, the pixclk_o period doubles to 4·P fast cycles, with 2·P cycles high and 2·P cycles low.
- R5: adcclk_o has a period of 4·P fast cycles in both modes, high for the first half. It rises only in the cycle after a launch_o pulse.
- R6: A delay setting D (0..15) moves every pixclk_o edge D fast cycles later relative to launch_o. With D = 0, pixclk_o changes in the cycle right after launch_o.
- R7: With invert_i = 1, pixclk_o is the complement of the non-inverted waveform, so the launch edge is a falling edge.
- R8: launch_o is a one-cycle pulse, once per pixclk period. It is asserted in the cycle before the undelayed launch edge, so a register enabled by it updates on that edge.
- R9: period_i, delay_i, invert_i and lowpwr_i are sampled only at the period boundary. A change made in mid-period leaves the current period unchanged and applies from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Fast clock at twice the master rate (one cycle = half-master step) |
| rst_ni | input | 1 | Active-low synchronous reset |
| period_i | input | PER_W | Pixel clock period in master clocks (0 acts as 1) |
| delay_i | input | DLY_W | Pixel clock delay in half-master steps |
| invert_i | input | 1 | Invert pixel clock so launch lands on its falling edge |
| lowpwr_i | input | 1 | Low-power readout: pixel clock period doubled |
| pixclk_o | output | 1 | Pixel clock |
| launch_o | output | 1 | One-cycle enable for data and sync launch registers |
| adcclk_o | output | 1 | ADC clock |

## Verification
In this section, "cycle c" is the fast-clock cycle in which launch_o is high. Without delay, pixclk_o and adcclk_o take their new values one cycle later, at c+1, because each passes through one output register after the phase state. pixclk_o then lags by a further D cycles. Settings driven in mid-period first show at c+1 of the next launch, because the shadow registers load on the same edge that raises launch_o.

For each scenario, the bench waits until the settings have settled for longer than one full delay line. It then locks onto a launch_o pulse, samples every output at the falling clock edge from c+1 onward, and compares each sample with a waveform computed from P, D, the inversion and the mode.

// File: rtl/pixclk_gen_pkg.sv
package pixclk_gen_pkg;
    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/pixclk_cfg_hold.sv
module pixclk_cfg_hold #(
    parameter int PER_W = 4,
    parameter int DLY_W = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 load_i,
    input  logic [PER_W-1:0]     period_i,
    input  logic [DLY_W-1:0]     delay_i,
    input  logic                 invert_i,
    input  logic                 lowpwr_i,
    output logic [PER_W:0]       half_o,
    output logic [DLY_W-1:0]     dly_o,
    output logic                 inv_o,
    output logic                 lp_o
);
    localparam int HALF_W = PER_W + 1;

    logic [PER_W-1:0]  per_eff;
    logic [HALF_W-1:0] half_n;

    // zero period behaves as one; low power doubles the phase length
    always_comb begin
        per_eff = (period_i == '0) ? PER_W'(1) : period_i;
        half_n  = lowpwr_i ? {per_eff, 1'b0} : {1'b0, per_eff};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            half_o <= HALF_W'(1);
            dly_o  <= DLY_W'(1);
            inv_o  <= 1'b0;
            lp_o   <= 1'b0;
        end else if (load_i) begin
            half_o <= half_n;
            dly_o  <= delay_i;
            inv_o  <= invert_i;
            lp_o   <= lowpwr_i;
        end
    end
endmodule

// File: rtl/pixclk_phase_fsm.sv
module pixclk_phase_fsm
    import pixclk_gen_pkg::*;
#(
    parameter int HALF_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [HALF_W-1:0] half_i,
    output logic              base_o,
    output logic              enter_o,
    output logic              tgl_o
);
    phase_e            st, st_n;
    logic [HALF_W-1:0] cnt;
    logic              last;

    assign last = (cnt == half_i - HALF_W'(1));

    // state register with phase counter and period toggle
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st    <= PH_LOAD;
            cnt   <= '0;
            tgl_o <= 1'b0;
        end else begin
            st  <= st_n;
            cnt <= (st_n != st) ? '0 : cnt + HALF_W'(1);
            if (enter_o)
                tgl_o <= (st == PH_LOAD) ? 1'b1 : ~tgl_o;
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            PH_LOAD: st_n = PH_HIGH;
            PH_HIGH: if (last) st_n = PH_LOW;
            PH_LOW:  if (last) st_n = PH_HIGH;
            default: st_n = PH_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        base_o  = (st == PH_HIGH);
        enter_o = (st_n == PH_HIGH) && (st != PH_HIGH);
    end
endmodule

// File: rtl/pixclk_delay_line.sv
module pixclk_delay_line #(
    parameter int DLY_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             din_i,
    input  logic [DLY_W-1:0] sel_i,
    output logic             dout_o
);
    localparam int TAPS = (1 << DLY_W) - 1;

    logic [TAPS-1:0] sh;

    generate
        if (TAPS == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (!rst_ni) sh <= '0;
                else         sh <= din_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i) begin
                if (!rst_ni) sh <= '0;
                else         sh <= {sh[TAPS-2:0], din_i};
            end
        end
    endgenerate

    // tap k delivers the input delayed by k cycles
    assign dout_o = (sel_i == '0) ? din_i : sh[sel_i - DLY_W'(1)];
endmodule

// File: rtl/pixclk_gen.sv
module pixclk_gen #(
    parameter int PER_W = 4,
    parameter int DLY_W = 4
) (
    input  logic             clk2x_i,
    input  logic             rst_ni,
    input  logic [PER_W-1:0] period_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             invert_i,
    input  logic             lowpwr_i,
    output logic             pixclk_o,
    output logic             launch_o,
    output logic             adcclk_o
);
    localparam int HALF_W = PER_W + 1;

    logic [HALF_W-1:0] half_s;
    logic [DLY_W-1:0]  dly_s;
    logic              inv_s;
    logic              lp_s;
    logic              base;
    logic              enter_high;
    logic              tgl;
    logic              tap;

    pixclk_cfg_hold #(.PER_W(PER_W), .DLY_W(DLY_W)) u_cfg (
        .clk_i    (clk2x_i),
        .rst_ni   (rst_ni),
        .load_i   (enter_high),
        .period_i (period_i),
        .delay_i  (delay_i),
        .invert_i (invert_i),
        .lowpwr_i (lowpwr_i),
        .half_o   (half_s),
        .dly_o    (dly_s),
        .inv_o    (inv_s),
        .lp_o     (lp_s)
    );

    pixclk_phase_fsm #(.HALF_W(HALF_W)) u_fsm (
        .clk_i   (clk2x_i),
        .rst_ni  (rst_ni),
        .half_i  (half_s),
        .base_o  (base),
        .enter_o (enter_high),
        .tgl_o   (tgl)
    );

    pixclk_delay_line #(.DLY_W(DLY_W)) u_dly (
        .clk_i  (clk2x_i),
        .rst_ni (rst_ni),
        .din_i  (base),
        .sel_i  (dly_s),
        .dout_o (tap)
    );

    always_ff @(posedge clk2x_i) begin
        if (!rst_ni) begin
            pixclk_o <= 1'b0;
            launch_o <= 1'b0;
            adcclk_o <= 1'b0;
        end else begin
            pixclk_o <= inv_s ^ tap;
            launch_o <= enter_high;
            adcclk_o <= lp_s ? base : tgl;
        end
    end
endmodule

// File: rtl/pixclk_gen_chk.sv
module pixclk_gen_chk #(
    parameter int DLY_W  = 4,
    parameter int HALF_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pixclk,
    input logic              launch,
    input logic              adcclk,
    input logic              enter_high,
    input logic [HALF_W-1:0] half_s,
    input logic [DLY_W-1:0]  dly_s,
    input logic              inv_s,
    input logic              lp_s
);
    AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);                                          // R8
    AST_NODELAY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && dly_s == '0 && !inv_s) |=> pixclk);                // R6
    AST_INVERT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && dly_s == '0 && inv_s) |=> !pixclk);                // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !enter_high |=> $stable({half_s, dly_s, inv_s, lp_s}));       // R9
    AST_ADC_RISE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adcclk) |-> $past(launch));                             // R5
    AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        half_s != '0);                                                // R3
endmodule

bind pixclk_gen pixclk_gen_chk #(.DLY_W(DLY_W), .HALF_W(HALF_W)) u_chk (
    .clk        (clk2x_i),
    .rst_n      (rst_ni),
    .pixclk     (pixclk_o),
    .launch     (launch_o),
    .adcclk     (adcclk_o),
    .enter_high (enter_high),
    .half_s     (half_s),
    .dly_s      (dly_s),
    .inv_s      (inv_s),
    .lp_s       (lp_s)
);

// File: tb/sim_pixclk_gen.sv
`timescale 1ns/1ps
module sim_pixclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] period = 4'd1;
    logic [3:0] delay = 4'd1;
    logic       invert = 1'b0;
    logic       lowpwr = 1'b0;
    logic       pixclk, launch, adcclk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    pixclk_gen u0 (
        .clk2x_i(clk), .rst_ni(rst_n), .period_i(period), .delay_i(delay),
        .invert_i(invert), .lowpwr_i(lowpwr),
        .pixclk_o(pixclk), .launch_o(launch), .adcclk_o(adcclk)
    );

    task automatic chk(input bit got, input bit exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    function automatic int pmod(input int a, input int m);
        return ((a % m) + m) % m;
    endfunction

    function automatic bit exp_pix(input int k, input int p, input int d, input bit inv, input bit lp);
        int pe = (p == 0) ? 1 : p;
        int h  = lp ? 2 * pe : pe;
        return inv ^ (pmod(k - d, 2 * h) < h);
    endfunction

    // waits for launch_o, steps to the next cycle; optionally requires adcclk_o high there
    task automatic sync_launch(input bit need_adc, output bit ok);
        ok = 1'b0;
        for (int t = 0; t < 400 && !ok; t++) begin
            @(negedge clk);
            if (launch) begin
                @(negedge clk);
                if (!need_adc || adcclk) ok = 1'b1;
            end
        end
    endtask

    task automatic run_pattern(input int p, input int d, input bit inv, input bit lp, input string req);
        bit ok;
        int pe = (p == 0) ? 1 : p;
        int h  = lp ? 2 * pe : pe;
        int a  = 4 * pe;
        @(negedge clk);
        period = 4'(p); delay = 4'(d); invert = inv; lowpwr = lp;
        repeat (100) @(negedge clk);
        sync_launch(1'b1, ok);
        chk(ok, 1'b1, "R5", "sync on launch with adc high");
        for (int k = 0; k < 2 * a; k++) begin
            if (k > 0) @(negedge clk);
            chk(pixclk, exp_pix(k, p, d, inv, lp), req, $sformatf("pixclk p=%0d d=%0d k=%0d", p, d, k));
            chk(adcclk, (k % a) < a / 2, "R5", $sformatf("adcclk p=%0d lp=%0b k=%0d", p, lp, k));
            chk(launch, (k % (2 * h)) == 2 * h - 1, "R8", $sformatf("launch p=%0d k=%0d", p, k));
        end
    endtask

    task automatic test_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(pixclk, 1'b0, "R1", "pixclk in reset");
        chk(launch, 1'b0, "R1", "launch in reset");
        chk(adcclk, 1'b0, "R1", "adcclk in reset");
        rst_n = 1'b1;
        // default period 1 delay 1: launch at cycle 1 after release, pixclk rises two later
        @(negedge clk);
        chk(launch, 1'b1, "R1", "first launch after reset");
        @(negedge clk);
        chk(pixclk, 1'b0, "R1", "pixclk held by default delay of 1");
        chk(adcclk, 1'b1, "R1", "adcclk first rise");
        @(negedge clk);
        chk(pixclk, 1'b1, "R1", "pixclk rises one step late");
    endtask

    // R9: settings changed in mid-period apply only after the current period
    task automatic test_midchange;
        bit ok;
        @(negedge clk);
        period = 4'd4; delay = 4'd0; invert = 1'b0; lowpwr = 1'b0;
        repeat (100) @(negedge clk);
        sync_launch(1'b0, ok);
        chk(ok, 1'b1, "R9", "sync on launch");
        for (int k = 0; k < 24; k++) begin
            if (k > 0) @(negedge clk);
            if (k < 8) begin
                chk(pixclk, exp_pix(k, 4, 0, 1'b0, 1'b0), "R9", $sformatf("old period kept k=%0d", k));
                chk(launch, k == 7, "R9", $sformatf("old launch k=%0d", k));
            end else begin
                chk(pixclk, exp_pix(k - 8, 2, 0, 1'b1, 1'b0), "R9", $sformatf("new setting k=%0d", k));
                chk(launch, ((k - 8) % 4) == 3, "R9", $sformatf("new launch k=%0d", k));
            end
            if (k == 2) begin
                period = 4'd2;
                invert = 1'b1;
            end
        end
    endtask

    initial begin
        test_reset();
        run_pattern(1, 0, 1'b0, 1'b0, "R2");
        run_pattern(3, 0, 1'b0, 1'b0, "R2");
        run_pattern(15, 0, 1'b0, 1'b0, "R2");
        run_pattern(0, 0, 1'b0, 1'b0, "R3");
        run_pattern(4, 0, 1'b0, 1'b1, "R4");
        run_pattern(2, 3, 1'b0, 1'b0, "R6");
        run_pattern(1, 5, 1'b0, 1'b0, "R6");
        run_pattern(3, 0, 1'b1, 1'b0, "R7");
        run_pattern(2, 2, 1'b1, 1'b1, "R7");
        test_midchange();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule